// File: doc/BRIEF.md
# Toggle Handshake Clock Domain Bridge

This block moves one data word at a time from a source clock domain into an unrelated destination clock domain. A single control wire crosses in each direction, and each wire carries its meaning as a change of level rather than as a pulse. The source raises `src_valid` for one cycle with a word on `src_data`. The request wire then flips, and the source reports `src_busy` until the flip has come back as an acknowledge. The word itself never goes through a synchronizer. The sender keeps it constant for the whole transfer, and the destination samples it only after it has seen the request change.

On the destination side the synchronized request is compared with its previous value. A difference produces `dst_strobe` for exactly one destination cycle, and in the same cycle the word appears on `dst_data`. The same event flips the acknowledge wire. When the source sees that flip through its own two-flop synchronizer, it drops `src_busy` and pulses `src_done`. Each domain has its own active-low reset. Reset takes effect asynchronously and is released only after two edges of that domain's clock.

Top module: `toggle_xfer_bridge`

## Requirements
- R1: A `src_valid` high at a source clock edge while `src_busy` is low starts a transfer: `src_busy` reads high from the next source cycle on.
- R2: A `src_valid` high while `src_busy` is high is ignored: no further destination capture takes place and no extra `src_done` pulse is produced.
- R3: `src_busy` falls once the acknowledge, after two source flip-flops, matches the request. `src_done` is high for exactly the one source cycle in which `src_busy` has just fallen.
- R4: Each transfer produces exactly one `dst_strobe`, one destination cycle wide. `dst_data` changes only in a cycle where `dst_strobe` is high.
- R5: The word on `dst_data` during `dst_strobe` equals the `src_data` that was held for that transfer. This holds for destination clocks faster than, slower than and close to the source clock.
- R6: Every destination capture flips the acknowledge level once, so each transfer completes on the source side exactly once.
- R7: Driving `src_rst_n` or `dst_rst_n` low clears that domain's outputs at once, without a clock: `src_busy`=0 and `src_done`=0, or `dst_strobe`=0 and `dst_data`=0.
- R8: After a reset input goes high, that domain stays in reset through its next two clock edges. A `src_valid` at the first source edge after release is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low, asynchronous assert |
| src_valid | input | 1 | One-cycle request to send `src_data` |
| src_data | input | WIDTH | Word to send, held until `src_done` |
| src_busy | output | 1 | Transfer in flight |
| src_done | output | 1 | One-cycle pulse when the transfer completes |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low, asynchronous assert |
| dst_strobe | output | 1 | One-cycle capture pulse |
| dst_data | output | WIDTH | Captured word |

## Verification
The bench runs random words at three clock ratios. At the slow destination clock, a design that treated the request as a pulse would lose transfers. At the fast destination clock, edge detection that went wrong would capture a word twice or stretch the strobe. Extra `src_valid` pulses are sent while a transfer is in flight; a source that failed to gate them would flip the request twice and cancel the transfer, or send a duplicate. Resets are applied in the middle of a transfer to check the asynchronous clear. A `src_valid` is placed on the first edge after release to catch a reset stretcher that is too short.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  // flip-flops in each synchronizer chain and in each reset stretcher
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/xfer_rst_sync.sv
module xfer_rst_sync #(
  parameter int unsigned STAGES = xfer_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] hold_q;
  logic [STAGES-1:0] hold_d;

  always_comb hold_d = {hold_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) hold_q <= '0;
    else         hold_q <= hold_d;
  end

  assign rst_n = hold_q[STAGES-1];
endmodule

// File: rtl/xfer_bit_sync.sv
module xfer_bit_sync #(
  parameter int unsigned STAGES = xfer_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xfer_src_side.sv
module xfer_src_side (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic ack_sync,
  output logic req,
  output logic busy,
  output logic done
);
  logic req_q, req_d;
  logic busy_q;
  logic launch;

  always_comb begin
    busy   = req_q ^ ack_sync;
    launch = valid & ~busy;
    req_d  = req_q ^ launch;
    done   = busy_q & ~busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      busy_q <= busy;
    end
  end

  assign req = req_q;

  // R1
  busy_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(valid));
  // R2
  req_hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(req_q));
endmodule

// File: rtl/xfer_dst_side.sv
module xfer_dst_side #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_sync,
  input  logic [WIDTH-1:0] data_in,
  output logic             strobe,
  output logic             ack,
  output logic [WIDTH-1:0] data
);
  logic             seen_q;
  logic             strobe_q, strobe_d;
  logic             ack_q, ack_d;
  logic [WIDTH-1:0] data_q, data_d;
  logic             edge_hit;

  always_comb begin
    edge_hit = req_sync ^ seen_q;
    strobe_d = edge_hit;
    ack_d    = ack_q ^ edge_hit;
    data_d   = edge_hit ? data_in : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= 1'b0;
      strobe_q <= 1'b0;
      ack_q    <= 1'b0;
      data_q   <= '0;
    end else begin
      seen_q   <= req_sync;
      strobe_q <= strobe_d;
      ack_q    <= ack_d;
      data_q   <= data_d;
    end
  end

  assign strobe = strobe_q;
  assign ack    = ack_q;
  assign data   = data_q;

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);
  // R4
  data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_q |-> $stable(data_q));
  // R6
  ack_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> (ack_q != $past(ack_q)));
endmodule

// File: rtl/toggle_xfer_bridge.sv
module toggle_xfer_bridge #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = xfer_pkg::SYNC_STAGES
) (
  input  logic             src_clk,
  input  logic             src_rst_n,
  input  logic             src_valid,
  input  logic [WIDTH-1:0] src_data,
  output logic             src_busy,
  output logic             src_done,
  input  logic             dst_clk,
  input  logic             dst_rst_n,
  output logic             dst_strobe,
  output logic [WIDTH-1:0] dst_data
);
  logic s_rst_n, d_rst_n;
  logic req_tgl, req_at_dst;
  logic ack_tgl, ack_at_src;

  xfer_rst_sync #(.STAGES(STAGES)) u_src_rst (
    .clk(src_clk), .arst_n(src_rst_n), .rst_n(s_rst_n));
  xfer_rst_sync #(.STAGES(STAGES)) u_dst_rst (
    .clk(dst_clk), .arst_n(dst_rst_n), .rst_n(d_rst_n));

  xfer_src_side u_src (
    .clk(src_clk), .rst_n(s_rst_n), .valid(src_valid), .ack_sync(ack_at_src),
    .req(req_tgl), .busy(src_busy), .done(src_done));

  xfer_bit_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(dst_clk), .rst_n(d_rst_n), .d(req_tgl), .q(req_at_dst));

  xfer_dst_side #(.WIDTH(WIDTH)) u_dst (
    .clk(dst_clk), .rst_n(d_rst_n), .req_sync(req_at_dst), .data_in(src_data),
    .strobe(dst_strobe), .ack(ack_tgl), .data(dst_data));

  xfer_bit_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(src_clk), .rst_n(s_rst_n), .d(ack_tgl), .q(ack_at_src));

  // R3
  done_ends_busy_chk: assert property (@(posedge src_clk) disable iff (!s_rst_n)
    src_done |-> $past(src_busy) && !src_busy);
endmodule

// File: tb/tb_toggle_xfer_bridge.sv
`timescale 1ns/1ps
module tb_toggle_xfer_bridge;
  localparam int W = 16;

  logic src_clk = 0, dst_clk = 0;
  logic src_rst_n = 0, dst_rst_n = 0;
  logic src_valid = 0;
  logic [W-1:0] src_data = '0;
  logic src_busy, src_done, dst_strobe;
  logic [W-1:0] dst_data;
  int dst_half = 6;

  toggle_xfer_bridge #(.WIDTH(W)) dut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
    .src_data(src_data), .src_busy(src_busy), .src_done(src_done),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_strobe(dst_strobe),
    .dst_data(dst_data));

  always #5 src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  int total = 0, bad = 0;
  int strobes = 0, dones = 0, mon_bad = 0;
  logic [W-1:0] got = '0, prev_data = '0;
  logic prev_strobe = 0, prev_rst = 0, prev_done = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // destination monitor: one-cycle strobe, data moves only with strobe
  always @(negedge dst_clk) begin
    if (dst_rst_n && prev_rst) begin
      if (dst_strobe) begin strobes++; got = dst_data; end
      if (dst_strobe && prev_strobe) mon_bad++;
      if (!dst_strobe && dst_data != prev_data) mon_bad++;
    end
    prev_strobe = dst_strobe;
    prev_data   = dst_data;
    prev_rst    = dst_rst_n;
  end

  // source monitor: done pulse count and width
  always @(negedge src_clk) begin
    if (src_done) dones++;
    if (src_done && prev_done) mon_bad++;
    prev_done = src_done;
  end

  task automatic send(input logic [W-1:0] word, input int extra, output bit ok);
    int s0 = strobes, d0 = dones;
    int n = 0;
    @(negedge src_clk);
    src_data = word; src_valid = 1;
    @(negedge src_clk);
    src_valid = 0;
    ok = src_busy; // R1
    for (int i = 0; i < extra; i++) begin
      src_valid = src_busy;    // R2: pulses while busy
      @(negedge src_clk);
      src_valid = 0;
    end
    while (dones == d0 && n < 2000) begin @(negedge src_clk); n++; end
    repeat (3) @(negedge dst_clk);
    repeat (3) @(negedge src_clk);
    ok = ok && (strobes == s0 + 1) && (dones == d0 + 1) && !src_busy && (got == word);
  endtask

  task automatic run_ratio(input int half, input string tag);
    bit ok;
    dst_half = half;
    repeat (4) @(negedge src_clk);
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] w = W'($urandom);
      int s0 = strobes;
      send(w, 0, ok);
      chk(ok, {"R5 ", tag}, int'(got), int'(w));
      chk(strobes == s0 + 1, "R4/R6 one capture", strobes - s0, 1);
    end
  endtask

  task automatic busy_ignore();
    bit ok;
    int d0 = dones, s0 = strobes;
    dst_half = 17;
    send(16'hA5C3, 5, ok);
    chk(strobes == s0 + 1, "R2 no extra capture", strobes - s0, 1);
    chk(dones == d0 + 1, "R2/R3 one done", dones - d0, 1);
    chk(got == 16'hA5C3, "R2 data", int'(got), 16'hA5C3);
  endtask

  task automatic reset_cases();
    bit ok;
    int s0;
    dst_half = 6;
    @(negedge src_clk);
    src_data = 16'h1234; src_valid = 1;
    @(negedge src_clk);
    src_valid = 0;
    #2;
    src_rst_n = 0; dst_rst_n = 0;
    #1;
    chk(!src_busy && !src_done, "R7 src clear", {src_busy, src_done}, 0);
    chk(!dst_strobe && dst_data == 0, "R7 dst clear", int'(dst_data), 0);
    repeat (4) @(negedge src_clk);
    s0 = strobes;
    src_rst_n = 1; dst_rst_n = 1;
    src_valid = 1;
    @(negedge src_clk);
    src_valid = 0;
    chk(!src_busy, "R8 valid on first edge ignored", src_busy, 0);
    repeat (10) @(negedge src_clk);
    chk(strobes == s0, "R8 no capture", strobes - s0, 0);
    send(16'h0F0F, 0, ok);
    chk(ok, "R8 works after release", int'(got), 16'h0F0F);
  endtask

  initial begin
    #1;
    chk(!src_busy && !src_done && !dst_strobe && dst_data == 0, "R7 reset state",
        {src_busy, src_done, dst_strobe}, 0);
    #40;
    src_rst_n = 1; dst_rst_n = 1;
    repeat (5) @(negedge src_clk);
    run_ratio(6, "near-equal");
    run_ratio(2, "dst fast");
    run_ratio(17, "dst slow");
    busy_ignore();
    reset_cases();
    chk(mon_bad == 0, "R4 strobe width / data quiet / R3 done width", mon_bad, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule